// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between six external control pins and a processor core. An update for one pin arrives as a pin index and a new level. The block keeps the last level of every pin and ignores an update that does not change it. Each pin then acts by its own sensitivity rule. Three pins copy their level into a pending-event flag: external interrupt, system management and soft reset. The machine-check pin latches a sticky flag on a falling edge. The checkstop pin stops the core while it is high. The hard reset pin raises a reset request while it is high.

The core sees a four-bit pending-event vector and a combined interrupt request, which is high whenever any event is pending. The core acknowledges events through a per-event clear input. A clear and a new set on the same edge resolve in favour of the set. The checkstop behaviour is a two-state machine. Its states are `CORE_RUN` and `CORE_STOPPED`. It takes the transition *stop* when the checkstop level changes to 1, and the transition *resume* when that level changes to 0.

Top module: `pin_conditioner`

## Requirements
- R1: An update whose level equals the stored level of that pin has no effect. For example, after the external-interrupt event is cleared while its pin stays high, another update of that pin to 1 leaves the event clear.
- R2: Pin index 0 (external interrupt) is level sensitive. A level change copies the new level into pending bit 0 on the next clock edge.
- R3: Pin index 1 (system management) is level sensitive. A level change copies the new level into pending bit 1.
- R4: Pin index 2 (machine check) sets pending bit 2 only on a change from 1 to 0. A rising change leaves bit 2 as it was, and the bit stays set until it is cleared.
- R5: Pin index 3 (checkstop) takes the machine to `CORE_STOPPED` (`core_halt`=1) when its level changes to 1. It returns to `CORE_RUN` (`core_halt`=0) when the level changes to 0. It touches no pending bit.
- R6: Pin index 5 (soft reset) is level sensitive. A level change copies the new level into pending bit 3.
- R7: `irq_req` is high exactly when at least one bit of `evt_pending` is set.
- R8: Pin index 4 (hard reset) drives no pending bit. `hreset_req` follows its stored level, high while that level is 1.
- R9: An update with pin index 6 or 7 is ignored. No output changes.
- R10: A set bit of `evt_clear` clears the matching pending bit on the same clock edge. If that bit is set on the same edge, the set wins.
- R11: After reset, all stored levels, all pending bits, `irq_req`, `core_halt` and `hreset_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | A pin update is presented this cycle |
| upd_pin | input | 3 | Index of the pin being updated (0..5 defined) |
| upd_level | input | 1 | New level of the addressed pin |
| evt_clear | input | 4 | Per-event clear from the core |
| evt_pending | output | 4 | Pending events: 0 external, 1 system management, 2 machine check, 3 soft reset |
| irq_req | output | 1 | Combined interrupt request |
| core_halt | output | 1 | Core stopped by checkstop |
| hreset_req | output | 1 | Hard reset request |

## Verification
Several rules are checked by assertions on every cycle:
- A matching or out-of-range update leaves the stored levels unchanged.
- A pending bit moves only on a pin change or a clear.
- A rising machine-check edge does nothing.
- A set beats a simultaneous clear.
- The halt state moves only with a checkstop change and lands on the new level.
- The reset request follows hard-reset pin changes.

Only the bench scenarios show end-to-end sequences. One is the re-arm rule, where a cleared level event stays clear until its pin toggles. Others are the sticky machine-check flag, the combined request over several events, and the absence of any effect from indices 6 and 7.

// File: rtl/pin_conditioner_pkg.sv
package pin_conditioner_pkg;

    localparam int NUM_PINS  = 6;
    localparam int PIN_W     = 3;
    localparam int NUM_EVT   = 4;

    localparam int PIN_EXT   = 0;
    localparam int PIN_SMI   = 1;
    localparam int PIN_MCHK  = 2;
    localparam int PIN_STOP  = 3;
    localparam int PIN_HRST  = 4;
    localparam int PIN_SRST  = 5;

    localparam int EVT_EXT   = 0;
    localparam int EVT_SMI   = 1;
    localparam int EVT_MCHK  = 2;
    localparam int EVT_SRST  = 3;

    typedef enum logic {
        CORE_RUN     = 1'b0,
        CORE_STOPPED = 1'b1
    } halt_state_e;

    // Which pin feeds each pending event.
    function automatic int evt_src_pin(int e);
        case (e)
            EVT_EXT:  return PIN_EXT;
            EVT_SMI:  return PIN_SMI;
            EVT_MCHK: return PIN_MCHK;
            default:  return PIN_SRST;
        endcase
    endfunction

    // Sticky falling-edge events versus level-copy events.
    function automatic bit evt_is_sticky(int e);
        return (e == EVT_MCHK);
    endfunction

endpackage

// File: rtl/pin_level_tracker.sv
module pin_level_tracker
    import pin_conditioner_pkg::*;
#(
    parameter int N_PINS = NUM_PINS,
    parameter int IDX_W  = PIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [IDX_W-1:0]  upd_pin,
    input  logic              upd_level,
    output logic [N_PINS-1:0] pin_chg
);

    logic [N_PINS-1:0] lvl_q;

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        assign pin_chg[i] = upd_valid && (upd_pin == IDX_W'(i)) && (upd_level != lvl_q[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lvl_q[i] <= 1'b0;
            else if (pin_chg[i])
                lvl_q[i] <= upd_level;
        end
    end

    // R1: a matching update leaves the stored levels unchanged
    assert_match_noop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_chg == '0) |=> (lvl_q == $past(lvl_q)));

    // R9: indices beyond the defined pins never strobe a change
    assert_bad_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (int'(upd_pin) >= N_PINS)) |-> (pin_chg == '0));

    assert_one_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pin_chg));

endmodule

// File: rtl/pending_events.sv
module pending_events
    import pin_conditioner_pkg::*;
#(
    parameter int N_EVT = NUM_EVT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_chg,
    input  logic             upd_level,
    input  logic [N_EVT-1:0] evt_clear,
    output logic [N_EVT-1:0] pend_q
);

    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        logic set_e;
        logic drop_e;

        if (evt_is_sticky(e)) begin : g_sticky
            assign set_e  = evt_chg[e] && !upd_level;
            assign drop_e = 1'b0;
        end else begin : g_level
            assign set_e  = evt_chg[e] && upd_level;
            assign drop_e = evt_chg[e] && !upd_level;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_q[e] <= 1'b0;
            else if (set_e)
                pend_q[e] <= 1'b1;
            else if (drop_e || evt_clear[e])
                pend_q[e] <= 1'b0;
        end

        // R10: set wins against a simultaneous clear
        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_chg[e] && evt_clear[e] && (upd_level != evt_is_sticky(e))) |=> pend_q[e]);

        // R1: no pin change and no clear keeps the pending bit
        assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt_chg[e] && !evt_clear[e]) |=> $stable(pend_q[e]));

        if (evt_is_sticky(e)) begin : g_chk_sticky
            // R4: a rising machine-check change has no effect
            assert_rise_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_chg[e] && upd_level && !evt_clear[e]) |=> $stable(pend_q[e]));
        end
    end

endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
    import pin_conditioner_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_chg,
    input  logic upd_level,
    output logic core_halt
);

    halt_state_e state_q;
    halt_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CORE_RUN:     if (stop_chg && upd_level)  state_d = CORE_STOPPED; // stop
            CORE_STOPPED: if (stop_chg && !upd_level) state_d = CORE_RUN;     // resume
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CORE_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        core_halt = (state_q == CORE_STOPPED);
    end

    // R5: halt lands on the new checkstop level
    assert_halt_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_chg |=> (core_halt == $past(upd_level)));

    // R5: halt moves only with a checkstop change
    assert_halt_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_chg |=> $stable(core_halt));

endmodule

// File: rtl/pin_conditioner.sv
module pin_conditioner
    import pin_conditioner_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_valid,
    input  logic [PIN_W-1:0]   upd_pin,
    input  logic               upd_level,
    input  logic [NUM_EVT-1:0] evt_clear,
    output logic [NUM_EVT-1:0] evt_pending,
    output logic               irq_req,
    output logic               core_halt,
    output logic               hreset_req
);

    logic [NUM_PINS-1:0] pin_chg;
    logic [NUM_EVT-1:0]  evt_chg;
    logic                hrst_q;

    pin_level_tracker #(.N_PINS(NUM_PINS), .IDX_W(PIN_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_pin   (upd_pin),
        .upd_level (upd_level),
        .pin_chg   (pin_chg)
    );

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_route
        assign evt_chg[e] = pin_chg[evt_src_pin(e)];
    end

    pending_events #(.N_EVT(NUM_EVT)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_chg   (evt_chg),
        .upd_level (upd_level),
        .evt_clear (evt_clear),
        .pend_q    (evt_pending)
    );

    halt_fsm u_halt (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_chg  (pin_chg[PIN_STOP]),
        .upd_level (upd_level),
        .core_halt (core_halt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hrst_q <= 1'b0;
        else if (pin_chg[PIN_HRST])
            hrst_q <= upd_level;
    end

    assign hreset_req = hrst_q;
    assign irq_req    = |evt_pending;

    // R8: reset request follows hard-reset pin changes
    assert_hreset_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_chg[PIN_HRST] |=> (hreset_req == $past(upd_level)));

    // R11: immediate check right after reset release
    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (evt_pending == '0));

endmodule

// File: tb/pin_conditioner_test.sv
module pin_conditioner_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_valid = 1'b0;
    logic [2:0] upd_pin = '0;
    logic       upd_level = 1'b0;
    logic [3:0] evt_clear = '0;
    logic [3:0] evt_pending;
    logic       irq_req;
    logic       core_halt;
    logic       hreset_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    pin_conditioner uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_valid   (upd_valid),
        .upd_pin     (upd_pin),
        .upd_level   (upd_level),
        .evt_clear   (evt_clear),
        .evt_pending (evt_pending),
        .irq_req     (irq_req),
        .core_halt   (core_halt),
        .hreset_req  (hreset_req)
    );

    task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // One cycle of stimulus; outputs are sampled at the following falling edge.
    task automatic apply(bit v, int pin, bit lvl, logic [3:0] clr);
        @(negedge clk);
        upd_valid = v;
        upd_pin   = 3'(pin);
        upd_level = lvl;
        evt_clear = clr;
        @(negedge clk);
        upd_valid = 1'b0;
        evt_clear = '0;
    endtask

    task automatic t_reset;
        chk("R11 pending", evt_pending, 4'b0000);
        chk("R11 irq", {3'b0, irq_req}, 4'b0000);
        chk("R11 halt", {3'b0, core_halt}, 4'b0000);
        chk("R11 hreset", {3'b0, hreset_req}, 4'b0000);
    endtask

    task automatic t_ext;
        apply(1, 0, 1, 4'b0000);
        chk("R2 ext high", evt_pending, 4'b0001);
        chk("R7 irq high", {3'b0, irq_req}, 4'b0001);
        apply(1, 0, 0, 4'b0000);
        chk("R2 ext low", evt_pending, 4'b0000);
        chk("R7 irq low", {3'b0, irq_req}, 4'b0000);
    endtask

    task automatic t_match;
        apply(1, 0, 1, 4'b0000);
        apply(0, 0, 0, 4'b0001);
        chk("R10 clear ext", evt_pending, 4'b0000);
        apply(1, 0, 1, 4'b0000);
        chk("R1 matching update", evt_pending, 4'b0000);
        apply(1, 0, 0, 4'b0000);
        apply(1, 0, 1, 4'b0000);
        chk("R1 re-armed", evt_pending, 4'b0001);
        apply(1, 0, 0, 4'b0000);
    endtask

    task automatic t_smi;
        apply(1, 1, 1, 4'b0000);
        chk("R3 smi high", evt_pending, 4'b0010);
        apply(1, 1, 0, 4'b0000);
        chk("R3 smi low", evt_pending, 4'b0000);
    endtask

    task automatic t_mchk;
        apply(1, 2, 1, 4'b0000);
        chk("R4 rising ignored", evt_pending, 4'b0000);
        apply(1, 2, 0, 4'b0000);
        chk("R4 falling sets", evt_pending, 4'b0100);
        apply(1, 2, 1, 4'b0000);
        chk("R4 sticky", evt_pending, 4'b0100);
        apply(0, 0, 0, 4'b0100);
        chk("R10 clear mchk", evt_pending, 4'b0000);
        apply(1, 2, 0, 4'b0100);
        chk("R10 set wins", evt_pending, 4'b0100);
        apply(0, 0, 0, 4'b0100);
    endtask

    task automatic t_stop;
        apply(1, 3, 1, 4'b0000);
        chk("R5 halted", {3'b0, core_halt}, 4'b0001);
        chk("R5 no pending", evt_pending, 4'b0000);
        apply(1, 3, 0, 4'b0000);
        chk("R5 released", {3'b0, core_halt}, 4'b0000);
    endtask

    task automatic t_hreset;
        apply(1, 4, 1, 4'b0000);
        chk("R8 request", {3'b0, hreset_req}, 4'b0001);
        chk("R8 no pending", evt_pending, 4'b0000);
        apply(1, 4, 0, 4'b0000);
        chk("R8 drop", {3'b0, hreset_req}, 4'b0000);
    endtask

    task automatic t_sreset;
        apply(1, 5, 1, 4'b0000);
        chk("R6 sreset high", evt_pending, 4'b1000);
        apply(1, 0, 1, 4'b0000);
        chk("R7 two events", evt_pending, 4'b1001);
        apply(0, 0, 0, 4'b1000);
        chk("R10 partial clear", evt_pending, 4'b0001);
        chk("R7 still high", {3'b0, irq_req}, 4'b0001);
        apply(1, 5, 0, 4'b0000);
        apply(1, 0, 0, 4'b0000);
        chk("R6 all clear", evt_pending, 4'b0000);
    endtask

    task automatic t_bad_index;
        apply(1, 0, 1, 4'b0000);
        apply(1, 6, 0, 4'b0000);
        apply(1, 7, 1, 4'b0000);
        chk("R9 pending unchanged", evt_pending, 4'b0001);
        chk("R9 halt unchanged", {3'b0, core_halt}, 4'b0000);
        chk("R9 hreset unchanged", {3'b0, hreset_req}, 4'b0000);
        apply(1, 6, 1, 4'b0000);
        apply(1, 7, 0, 4'b0000);
        chk("R9 pending again", evt_pending, 4'b0001);
        apply(1, 0, 0, 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ext();
        t_match();
        t_smi();
        t_mchk();
        t_stop();
        t_hreset();
        t_sreset();
        t_bad_index();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule